// File: doc/BRIEF.md
# Shift, Rotate and Nibble-Swap Unit

This block is the execution stage for the prefixed bit-manipulation group of a small 8-bit CPU. Each accepted request carries an operand byte, the current carry flag and a 3-bit operation code. One clock later the block presents the shifted, rotated or swapped byte together with the four condition flags: zero, subtract, half-carry and carry. Eight operations are provided: circular rotate in either direction, rotate through carry in either direction, arithmetic shift left, sign-preserving arithmetic shift right, logical shift right and nibble exchange.

The operand may come from a register or from the memory byte addressed by the HL pair. That choice is made outside the block, which only receives a flag telling it the source. It returns the instruction's cycle cost for that source, so the sequencer can pace the next fetch. The cost is 2 cycles for a register operand and longer for a memory operand.

Top module: `bitop_shift_unit`

## Requirements
- R1: A request presented with `in_valid` high at a rising edge produces `out_valid` high and its result on all outputs after that same edge, so the result is visible for one cycle.
- R2: Code 0 rotates circularly left: bit 7 goes to both bit 0 and carry. Code 1 rotates circularly right: bit 0 goes to both bit 7 and carry.
- R3: Code 2 rotates left through carry: the incoming carry enters bit 0 and bit 7 leaves into carry. Code 3 rotates right through carry: the incoming carry enters bit 7 and bit 0 leaves into carry.
- R4: Code 4 is the arithmetic left shift: bit 7 goes to carry, the other bits move up one place, and bit 0 becomes 0.
- R5: Code 5 is the arithmetic right shift: bit 7 keeps its value, the bits move down one place, and bit 0 goes to carry.
- R6: Code 7 is the logical right shift: bit 7 becomes 0, the bits move down one place, and bit 0 goes to carry.
- R7: Code 6 exchanges bits 7..4 with bits 3..0 and always clears carry.
- R8: The zero flag is 1 exactly when the result byte is 0. The subtract and half-carry flags are 0 after every operation.
- R9: `out_cycles` reports 2 when `in_from_mem` was 0 for the request and 4 when it was 1.
- R10: In a cycle with `in_valid` low, `out_valid` drops to 0, and result, flags and cycle count keep their previous values whatever the other inputs do.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code (see R2 to R7) |
| in_operand | input | 8 | Operand byte |
| in_carry | input | 1 | Current carry flag |
| in_from_mem | input | 1 | 1 when the operand came from memory |
| out_valid | output | 1 | Result is for a request in the previous cycle |
| out_result | output | 8 | Result byte |
| out_zero | output | 1 | Zero flag |
| out_sub | output | 1 | Subtract flag |
| out_half | output | 1 | Half-carry flag |
| out_carry | output | 1 | Carry flag |
| out_cycles | output | 3 | Instruction cycle cost |

## Verification
The bench builds the unit with its default parameters: an 8-bit data path and cycle costs of 2 and 4. At that width a hand-written table can cover every operation code with operands that push a 1 out of each end, that pull the incoming carry in, and that collapse the byte to zero. Directed steps then test reset in the middle of a run and idle cycles in which the operand and code change but must not reach the outputs.

// File: rtl/bitop_shift_pkg.sv
package bitop_shift_pkg;

    typedef enum logic [2:0] {
        OP_ROTL_CIRC  = 3'd0,
        OP_ROTR_CIRC  = 3'd1,
        OP_ROTL_CARRY = 3'd2,
        OP_ROTR_CARRY = 3'd3,
        OP_SHL_ARITH  = 3'd4,
        OP_SHR_ARITH  = 3'd5,
        OP_NIB_SWAP   = 3'd6,
        OP_SHR_LOGIC  = 3'd7
    } bitop_e;

endpackage

// File: rtl/bitop_shift_core.sv
module bitop_shift_core
    import bitop_shift_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bitop_e             op,
    input  logic [DATA_W-1:0]  operand,
    input  logic               carry_in,
    output logic [DATA_W-1:0]  result,
    output logic               shifted_out
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    logic top_bit;
    logic low_bit;

    assign top_bit = operand[MSB];
    assign low_bit = operand[0];

    always_comb begin
        result      = operand;
        shifted_out = 1'b0;
        unique case (op)
            OP_ROTL_CIRC: begin
                result      = {operand[MSB-1:0], top_bit};
                shifted_out = top_bit;
            end
            OP_ROTR_CIRC: begin
                result      = {low_bit, operand[MSB:1]};
                shifted_out = low_bit;
            end
            OP_ROTL_CARRY: begin
                result      = {operand[MSB-1:0], carry_in};
                shifted_out = top_bit;
            end
            OP_ROTR_CARRY: begin
                result      = {carry_in, operand[MSB:1]};
                shifted_out = low_bit;
            end
            OP_SHL_ARITH: begin
                result      = {operand[MSB-1:0], 1'b0};
                shifted_out = top_bit;
            end
            OP_SHR_ARITH: begin
                result      = {top_bit, operand[MSB:1]};
                shifted_out = low_bit;
            end
            OP_NIB_SWAP: begin
                result      = {operand[HALF-1:0], operand[MSB:HALF]};
                shifted_out = 1'b0;
            end
            OP_SHR_LOGIC: begin
                result      = {1'b0, operand[MSB:1]};
                shifted_out = low_bit;
            end
            default: begin
                result      = operand;
                shifted_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bitop_flag_gen.sv
module bitop_flag_gen
    import bitop_shift_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bitop_e             op,
    input  logic [DATA_W-1:0]  result,
    input  logic               shifted_out,
    output logic               zero_flag,
    output logic               sub_flag,
    output logic               half_flag,
    output logic               carry_flag
);
    always_comb begin
        zero_flag  = (result == '0);
        sub_flag   = 1'b0;
        half_flag  = 1'b0;
        carry_flag = (op == OP_NIB_SWAP) ? 1'b0 : shifted_out;
    end

endmodule

// File: rtl/bitop_cycle_sel.sv
module bitop_cycle_sel #(
    parameter int REG_CYCLES = 2,
    parameter int MEM_CYCLES = 4,
    parameter int CYC_W      = 3
) (
    input  logic             from_mem,
    output logic [CYC_W-1:0] cycles
);
    localparam logic [CYC_W-1:0] REG_COST = CYC_W'(REG_CYCLES);
    localparam logic [CYC_W-1:0] MEM_COST = CYC_W'(MEM_CYCLES);

    always_comb begin
        cycles = from_mem ? MEM_COST : REG_COST;
    end

endmodule

// File: rtl/bitop_shift_unit.sv
module bitop_shift_unit
    import bitop_shift_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int REG_CYCLES = 2,
    parameter int MEM_CYCLES = 4,
    parameter int CYC_W      = $clog2(MEM_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [DATA_W-1:0] in_operand,
    input  logic              in_carry,
    input  logic              in_from_mem,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_zero,
    output logic              out_sub,
    output logic              out_half,
    output logic              out_carry,
    output logic [CYC_W-1:0]  out_cycles
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] value;
        logic              z;
        logic              n;
        logic              h;
        logic              c;
        logic [CYC_W-1:0]  cycles;
    } out_state_t;

    bitop_e             op_sel;
    logic [DATA_W-1:0]  core_result;
    logic               core_out_bit;
    logic               flg_z, flg_n, flg_h, flg_c;
    logic [CYC_W-1:0]   cost;
    out_state_t         state_d, state_q;

    assign op_sel = bitop_e'(in_op);

    bitop_shift_core #(.DATA_W(DATA_W)) u_core (
        .op          (op_sel),
        .operand     (in_operand),
        .carry_in    (in_carry),
        .result      (core_result),
        .shifted_out (core_out_bit)
    );

    bitop_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .op          (op_sel),
        .result      (core_result),
        .shifted_out (core_out_bit),
        .zero_flag   (flg_z),
        .sub_flag    (flg_n),
        .half_flag   (flg_h),
        .carry_flag  (flg_c)
    );

    bitop_cycle_sel #(
        .REG_CYCLES (REG_CYCLES),
        .MEM_CYCLES (MEM_CYCLES),
        .CYC_W      (CYC_W)
    ) u_cost (
        .from_mem (in_from_mem),
        .cycles   (cost)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.value  = core_result;
            state_d.z      = flg_z;
            state_d.n      = flg_n;
            state_d.h      = flg_h;
            state_d.c      = flg_c;
            state_d.cycles = cost;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.valid;
    assign out_result = state_q.value;
    assign out_zero   = state_q.z;
    assign out_sub    = state_q.n;
    assign out_half   = state_q.h;
    assign out_carry  = state_q.c;
    assign out_cycles = state_q.cycles;

    assert_sra_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_SHR_ARITH) |=>
            (out_result[DATA_W-1] == $past(in_operand[DATA_W-1])));

    assert_swap_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_NIB_SWAP) |=> !out_carry);

    assert_nh_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!out_sub && !out_half));

    assert_zero_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_zero == (out_result == '0)));

    assert_mem_cost_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_from_mem) |=> (out_cycles == CYC_W'(MEM_CYCLES)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_carry)));

    assert_shl_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_SHL_ARITH) |=> !out_result[0]);

endmodule

// File: tb/bitop_shift_unit_bench.sv
module bitop_shift_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    // {op[2:0], operand[7:0], carry_in, from_mem, result[7:0], zero, carry}
    localparam logic [22:0] VEC [NVEC] = '{
        {3'd0, 8'h85, 1'b0, 1'b0, 8'h0B, 1'b0, 1'b1},
        {3'd0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0},
        {3'd1, 8'h01, 1'b0, 1'b0, 8'h80, 1'b0, 1'b1},
        {3'd1, 8'h8A, 1'b1, 1'b1, 8'h45, 1'b0, 1'b0},
        {3'd2, 8'h80, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
        {3'd2, 8'h11, 1'b1, 1'b1, 8'h23, 1'b0, 1'b0},
        {3'd3, 8'h01, 1'b1, 1'b0, 8'h80, 1'b0, 1'b1},
        {3'd3, 8'h01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1},
        {3'd4, 8'hFF, 1'b1, 1'b0, 8'hFE, 1'b0, 1'b1},
        {3'd4, 8'h80, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1},
        {3'd5, 8'h81, 1'b0, 1'b0, 8'hC0, 1'b0, 1'b1},
        {3'd5, 8'h7E, 1'b1, 1'b1, 8'h3F, 1'b0, 1'b0},
        {3'd7, 8'h81, 1'b1, 1'b0, 8'h40, 1'b0, 1'b1},
        {3'd7, 8'h01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1},
        {3'd6, 8'hA5, 1'b1, 1'b0, 8'h5A, 1'b0, 1'b0},
        {3'd6, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_op = '0;
    logic [7:0] in_operand = '0;
    logic       in_carry = 1'b0;
    logic       in_from_mem = 1'b0;
    logic       out_valid;
    logic [7:0] out_result;
    logic       out_zero, out_sub, out_half, out_carry;
    logic [2:0] out_cycles;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_shift_unit u_bitop_shift_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_op       (in_op),
        .in_operand  (in_operand),
        .in_carry    (in_carry),
        .in_from_mem (in_from_mem),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_zero    (out_zero),
        .out_sub     (out_sub),
        .out_half    (out_half),
        .out_carry   (out_carry),
        .out_cycles  (out_cycles)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R2";
            3'd2, 3'd3: return "R3";
            3'd4:       return "R4";
            3'd5:       return "R5";
            3'd6:       return "R7";
            default:    return "R6";
        endcase
    endfunction

    task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic cin, input logic mem);
        @(negedge clk);
        in_valid    = 1'b1;
        in_op       = op;
        in_operand  = a;
        in_carry    = cin;
        in_from_mem = mem;
        @(negedge clk);
        in_valid    = 1'b0;
    endtask

    task automatic check_reset_state();
        check("R11", "valid", int'(out_valid), 0);
        check("R11", "result", int'(out_result), 0);
        check("R11", "flags", int'({out_zero, out_sub, out_half, out_carry}), 0);
        check("R11", "cycles", int'(out_cycles), 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [7:0] held;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [22:0] v;
            string       r;
            v = VEC[i];
            r = op_req(v[22:20]);
            issue(v[22:20], v[19:12], v[11], v[10]);
            check("R1", "valid", int'(out_valid), 1);
            check(r, "result", int'(out_result), int'(v[9:2]));
            check(r, "carry", int'(out_carry), int'(v[0]));
            check("R8", "zero", int'(out_zero), int'(v[1]));
            check("R8", "sub/half", int'({out_sub, out_half}), 0);
            check("R9", "cycles", int'(out_cycles), v[10] ? 4 : 2);
        end

        // R10: idle cycles with changing inputs leave outputs untouched
        issue(3'd4, 8'h41, 1'b0, 1'b1);
        held = out_result;
        check("R4", "result", int'(held), 8'h82);
        in_op = 3'd6; in_operand = 8'hF0; in_carry = 1'b1; in_from_mem = 1'b0;
        @(negedge clk);
        check("R10", "valid", int'(out_valid), 0);
        check("R10", "result", int'(out_result), int'(held));
        check("R10", "carry", int'(out_carry), 0);
        check("R10", "zero", int'(out_zero), 0);
        check("R10", "cycles", int'(out_cycles), 4);
        in_operand = 8'h00;
        @(negedge clk);
        check("R10", "result2", int'(out_result), int'(held));

        // R3 carry-in sensitivity: same operand, carry differs
        issue(3'd3, 8'h00, 1'b1, 1'b0);
        check("R3", "rr cin=1", int'(out_result), 8'h80);
        check("R3", "rr carry", int'(out_carry), 0);

        // R11: reset in the middle of a run
        issue(3'd0, 8'hFF, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule